// File: doc/BRIEF.md
# Handshaked Bus Master Interface with Per-Access Arbitration

This block is the memory interface unit of a small processor. The processor's internal units give it one access at a time: a byte read, a byte write, or the acquisition of an interrupt vector number from one of two interrupting controllers. The block latches the access into its address and data registers. It requests the shared bus from an external arbiter and waits for the grant. It then runs a fully interlocked cycle: the address and strobe stay up until the slave raises its completion line, and the request is released only after that line has fallen again.

Every byte is a separate arbitration and bus cycle. A multi-byte instruction fetch is therefore a series of single-byte reads, one per address. The data path is 8 bits wide and the address space is 64K bytes. A busy/done pair tells the requesting unit when the block is occupied and when the data register holds a valid result or the write has finished.

Top module: `mbus_master`

## Requirements
- R1: While reset is high and on the first cycle after it, bus_req, busy, done, all four strobe lines and dbus_oe are low, and abus and dbus_out are zero.
- R2: An access is accepted on a clock edge where req_valid is high, busy is low and bus_grant is low. bus_req rises on that edge and stays low otherwise. No strobe rises before bus_grant has been sampled high, and the strobe for the access rises on the first edge that samples bus_grant high.
- R3: A read (req_kind = 0) asserts only rd_strb, with abus equal to the latched address. The strobe holds until the edge that samples fc_in high and drops on that edge.
- R4: A write (req_kind = 1) asserts only wr_strb, with dbus_oe high and dbus_out equal to the latched write byte while the strobe is up.
- R5: For a read or a vector cycle, the byte on dbus_in at the edge that samples fc_in high is loaded into the data register and appears on rdata no later than done.
- R6: bus_req stays high for the whole cycle and falls on the edge that samples fc_in low after completion. done is high for exactly that one cycle.
- R7: req_kind = 2 asserts only vack0 and req_kind = 3 asserts only vack1 in place of a read strobe. The returned byte is captured as in R5.
- R8: req_valid while busy is high is ignored. No extra bus cycle or done pulse results, and the access already under way keeps its own address and data.
- R9: After a cycle, bus_req does not rise again until bus_grant has been sampled low. busy stays high until then.
- R10: At most one of rd_strb, wr_strb, vack0 and vack1 is high at any time, and a strobe is only high while bus_req is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request from a processor unit |
| req_kind | input | 2 | 0 read, 1 write, 2 vector from controller 0, 3 vector from controller 1 |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Data register contents |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| abus | output | 16 | Address lines, zero when the bus is not held |
| dbus_out | output | 8 | Data lines driven during a write |
| dbus_oe | output | 1 | Data line drive enable |
| dbus_in | input | 8 | Data lines from the slave |
| rd_strb | output | 1 | Read strobe |
| wr_strb | output | 1 | Write strobe |
| vack0 | output | 1 | Vector acknowledge to controller 0 |
| vack1 | output | 1 | Vector acknowledge to controller 1 |
| fc_in | input | 1 | Slave completion line |

## Verification
All outputs are registered, so each result is due exactly one clock edge after the input that causes it is sampled. The strobe comes one edge after the grant is first high. The strobe drops and the data is captured one edge after completion rises. done and the request drop come one edge after completion falls. The bench's arbiter and slave models record the cycle in which they change grant or completion. The monitor, sampling on the falling edge, compares each strobe edge and done pulse against those stamps plus one, and compares address, data and strobe identity against the scoreboard entry.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;
  localparam int KIND_W    = 2;
  localparam int NUM_LINES = 1 << KIND_W;

  localparam logic [KIND_W-1:0] KIND_RD = 2'd0;
  localparam logic [KIND_W-1:0] KIND_WR = 2'd1;
  localparam logic [KIND_W-1:0] KIND_V0 = 2'd2;
  localparam logic [KIND_W-1:0] KIND_V1 = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_STRB,
    ST_REL,
    ST_DROP
  } phase_t;
endpackage

// File: rtl/mbus_ctrl.sv
`timescale 1ns/1ps
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       bus_grant,
  input  logic                       fc_in,
  input  logic [KIND_W-1:0]          kind_q,
  output logic                       load,
  output logic                       capture,
  output logic                       bus_req,
  output logic                       drive,
  output logic                       busy,
  output logic                       done,
  output logic [NUM_LINES-1:0]       lines
);
  phase_t               phase;
  logic                 start_cyc;
  logic [NUM_LINES-1:0] line_nxt;

  assign load      = (phase == ST_IDLE) && req_valid && !bus_grant;
  assign start_cyc = (phase == ST_ARB) && bus_grant;
  assign capture   = (phase == ST_STRB) && fc_in;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign line_nxt[i] = start_cyc ? (kind_q == KIND_W'(i))
                                   : (capture ? 1'b0 : lines[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= ST_IDLE;
      bus_req <= 1'b0;
      drive   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      lines   <= '0;
    end else begin
      done  <= 1'b0;
      lines <= line_nxt;
      unique case (phase)
        ST_IDLE: if (load) begin
          phase   <= ST_ARB;
          bus_req <= 1'b1;
          busy    <= 1'b1;
        end
        ST_ARB: if (bus_grant) begin
          phase <= ST_STRB;
          drive <= 1'b1;
        end
        ST_STRB: if (fc_in) phase <= ST_REL;
        ST_REL: if (!fc_in) begin
          phase   <= ST_DROP;
          bus_req <= 1'b0;
          drive   <= 1'b0;
          done    <= 1'b1;
        end
        ST_DROP: if (!bus_grant) begin
          phase <= ST_IDLE;
          busy  <= 1'b0;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // R10
  one_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lines));

  // R10
  line_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (lines != '0) |-> bus_req);

  // R2
  line_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lines != '0) |-> $past(bus_grant));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((lines != '0) && !fc_in) |=> $stable(lines));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_req_low_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_req && $past(bus_req)));

  // R9
  fresh_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !$past(bus_grant));
endmodule

// File: rtl/mbus_datapath.sv
`timescale 1ns/1ps
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              capture,
  input  logic              drive,
  input  logic              wr_line,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     dbus_in,
  output logic [KIND_W-1:0] kind_q,
  output logic [AW-1:0]     abus,
  output logic [DW-1:0]     dbus_out,
  output logic              dbus_oe,
  output logic [DW-1:0]     rdata
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      kind_q <= KIND_RD;
    end else if (load) begin
      addr_q <= req_addr;
      data_q <= req_wdata;
      kind_q <= req_kind;
    end else if (capture && (kind_q != KIND_WR)) begin
      data_q <= dbus_in;
    end
  end

  assign abus     = drive ? addr_q : '0;
  assign dbus_oe  = wr_line;
  assign dbus_out = wr_line ? data_q : '0;
  assign rdata    = data_q;

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (capture && (kind_q != KIND_WR)) |=> (rdata == $past(dbus_in)));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (drive && !load) |=> (!drive || $stable(abus)));
endmodule

// File: rtl/mbus_master.sv
`timescale 1ns/1ps
module mbus_master
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [AW-1:0]     abus,
  output logic [DW-1:0]     dbus_out,
  output logic              dbus_oe,
  input  logic [DW-1:0]     dbus_in,
  output logic              rd_strb,
  output logic              wr_strb,
  output logic              vack0,
  output logic              vack1,
  input  logic              fc_in
);
  logic                 load, capture, drive;
  logic [KIND_W-1:0]    kind_q;
  logic [NUM_LINES-1:0] lines;

  mbus_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .bus_grant (bus_grant),
    .fc_in     (fc_in),
    .kind_q    (kind_q),
    .load      (load),
    .capture   (capture),
    .bus_req   (bus_req),
    .drive     (drive),
    .busy      (busy),
    .done      (done),
    .lines     (lines)
  );

  mbus_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .capture   (capture),
    .drive     (drive),
    .wr_line   (lines[KIND_WR]),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dbus_in   (dbus_in),
    .kind_q    (kind_q),
    .abus      (abus),
    .dbus_out  (dbus_out),
    .dbus_oe   (dbus_oe),
    .rdata     (rdata)
  );

  assign rd_strb = lines[KIND_RD];
  assign wr_strb = lines[KIND_WR];
  assign vack0   = lines[KIND_V0];
  assign vack1   = lines[KIND_V1];
endmodule

// File: tb/sim_mbus_master.sv
`timescale 1ns/1ps
module sim_mbus_master;
  typedef struct packed {
    logic [1:0]  k;
    logic [15:0] a;
    logic [7:0]  d;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, bus_req, dbus_oe, rd_strb, wr_strb, vack0, vack1;
  logic [7:0] rdata, dbus_out;
  logic [15:0] abus;
  logic bus_grant = 1'b0;
  logic fc_in = 1'b0;
  logic [7:0] dbus_in = '0;

  int checks = 0, errors = 0, cyc = 0;
  int g_dly = 1, s_dly = 1, gcnt = 0, scnt = 0;
  int g_set = -10, f_set = -10, f_clr = -10;
  int pushed = 0, popped = 0;
  logic [3:0] prev_strb = '0;
  logic prev_done = 1'b0, prev_req = 1'b0, prev_grant = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  mbus_master u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .bus_req(bus_req), .bus_grant(bus_grant), .abus(abus),
    .dbus_out(dbus_out), .dbus_oe(dbus_oe), .dbus_in(dbus_in),
    .rd_strb(rd_strb), .wr_strb(wr_strb), .vack0(vack0), .vack1(vack1),
    .fc_in(fc_in)
  );

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor, arbiter model and slave model
  always @(negedge clk) begin
    logic [3:0] strb;
    strb = {vack1, vack0, wr_strb, rd_strb};
    if (!rst) begin
      // R10: one strobe at most, only while requesting
      if (!$onehot0(strb) || (strb != 0 && !bus_req))
        chk(0, "R10 strobe set", {27'd0, bus_req, strb}, 32'd0);
      // R9: request only rises after grant seen low
      if (bus_req && !prev_req)
        chk(!prev_grant, "R9 request after grant low", prev_grant, 0);
      if (strb != 0 && prev_strb == 0) begin
        chk(cyc == g_set + 1, "R2 strobe one edge after grant", cyc, g_set + 1);
        if (q.size() == 0) chk(0, "R8 strobe without access", strb, 0);
        else begin
          chk(strb == (4'b1 << q[0].k), "R3/R4/R7 strobe line", strb, 4'b1 << q[0].k);
          chk(abus == q[0].a, "R3 address lines", abus, q[0].a);
          if (q[0].k == 2'd1)
            chk(dbus_oe && dbus_out == q[0].d, "R4 write data", {dbus_oe, dbus_out}, {1'b1, q[0].d});
        end
      end
      if (strb == 0 && prev_strb != 0)
        chk(cyc == f_set + 1, "R3 strobe drop after completion", cyc, f_set + 1);
      if (done) begin
        chk(!prev_done, "R6 done single cycle", prev_done, 0);
        chk(cyc == f_clr + 1 && !bus_req, "R6 done and release timing", cyc, f_clr + 1);
        if (q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          if (q[0].k != 2'd1)
            chk(rdata == q[0].d, q[0].k[1] ? "R7 vector byte" : "R5 read byte", rdata, q[0].d);
          void'(q.pop_front());
          popped++;
        end
      end
      // arbiter model
      if (bus_req && !bus_grant) begin
        if (gcnt + 1 >= g_dly) begin bus_grant = 1'b1; g_set = cyc; gcnt = 0; end
        else gcnt++;
      end else if (!bus_req && bus_grant) begin
        if (gcnt + 1 >= 3) begin bus_grant = 1'b0; gcnt = 0; end
        else gcnt++;
      end
      // slave model
      if (strb != 0 && !fc_in) begin
        if (scnt + 1 >= s_dly) begin
          fc_in = 1'b1; f_set = cyc; scnt = 0;
          dbus_in = vack0 ? 8'h21 : vack1 ? 8'h42 : rd_strb ? mem_val(abus) : 8'h00;
        end else scnt++;
      end else if (strb == 0 && fc_in) begin
        fc_in = 1'b0; f_clr = cyc; dbus_in = 8'h00;
      end
    end
    prev_strb  = strb;
    prev_done  = done;
    prev_req   = bus_req;
    prev_grant = bus_grant;
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic access(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d,
                        input int gd, input int sd, input bit poke);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    g_dly = gd;
    s_dly = sd;
    it.k = k;
    it.a = a;
    it.d = (k == 2'd1) ? d : (k == 2'd2) ? 8'h21 : (k == 2'd3) ? 8'h42 : mem_val(a);
    q.push_back(it);
    pushed++;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!busy);
    req_valid = 1'b0;
    if (poke) begin
      // R8: a second request during the access must be ignored
      req_valid = 1'b1; req_kind = 2'd1; req_addr = ~a; req_wdata = ~d;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({bus_req, busy, done, rd_strb, wr_strb, vack0, vack1, dbus_oe} == 8'd0 &&
        abus == 16'd0 && dbus_out == 8'd0, "R1 reset outputs",
        {bus_req, busy, done, rd_strb, wr_strb, vack0, vack1, dbus_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({bus_req, busy, done, rd_strb, wr_strb, vack0, vack1} == 7'd0 && abus == 16'd0,
        "R1 first cycle after reset", {bus_req, busy, done}, 0);
    access(2'd0, 16'h1234, 8'h00, 1, 1, 0);   // R3 read, fast
    access(2'd1, 16'h0040, 8'hC3, 4, 2, 0);   // R4 write
    access(2'd0, 16'hFFFF, 8'h00, 2, 5, 0);   // R5 top address
    access(2'd1, 16'h0000, 8'hFF, 1, 3, 0);   // R4 bottom address
    access(2'd2, 16'h0000, 8'h00, 3, 2, 0);   // R7 vector 0
    access(2'd3, 16'h0000, 8'h00, 1, 4, 0);   // R7 vector 1
    access(2'd0, 16'h2000, 8'h00, 3, 4, 1);   // R8 poke during read
    access(2'd1, 16'h3000, 8'h5A, 3, 4, 1);   // R8 poke during write
    for (int pc = 16'h0100; pc < 16'h0104; pc++)   // R2 per-byte fetch
      access(2'd0, 16'(pc), 8'h00, (pc % 3) + 1, (pc % 2) + 1, 0);
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(popped == pushed && !busy && !bus_req, "R8 done count", popped, pushed);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule